// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader

This block fetches a 64-word configuration image from a three-wire serial EEPROM once reset is released, and again each time software pulses `start`. The EEPROM pins are shared with another agent, so the block first raises a bus request and waits for a grant before it drives any pin. If the grant does not arrive within a fixed number of polls, the block stops with a timeout flag. Each word is read with its own chip-select frame. The frame carries a three-bit read opcode, then the word address, then sixteen clocked data bits. A strap input selects a 6-bit or an 8-bit address field, to suit a 64-word or a 256-word part.

The words go into an internal array, most significant bit first, and a running 16-bit sum is kept. When the last word arrives, the block compares the sum with a fixed signature and raises either the pass flag or the fail flag. A random-access read port and a 48-bit station address output built from the first three words become valid once `done` is high. The serial clock comes from the system clock through a divider. Every serial step (setup, clock high, clock low) lasts one divider period.

Top module: `mw_eeprom_loader`

## Requirements
- R1: `arb_req` rises before chip select is first asserted and stays high while `ee_cs` is high. It is low whenever `done` is high.
- R2: If `arb_gnt` is not seen within GNT_POLLS divider periods after the request, the load ends with `done`=1 and `grant_timeout`=1. Both checksum flags stay 0 and `ee_cs` is never asserted.
- R3: Every frame shifts out the opcode bits 1,1,0 and then the word address, MSB first. The address is 6 bits when `size_256` was 0 at start and 8 bits (upper two zero) when it was 1, so a frame has 9 or 11 command bits.
- R4: `ee_di` is set one divider period before `ee_sk` rises and holds while `ee_sk` is high. Each high phase of `ee_sk` lasts exactly DIV clock cycles.
- R5: After the address, 16 clock pulses read the data word MSB first. `ee_do` is sampled while `ee_sk` is high.
- R6: Words are read in ascending address order, 0 to 63, one chip-select frame per word. When `ee_cs` falls, `ee_sk` and `ee_di` are both 0.
- R7: At the end of a complete load, `csum_ok`=1 if the 16-bit wrapping sum of the 64 words equals 16'hBABA. Otherwise `csum_err`=1. At most one of `csum_ok`, `csum_err` and `grant_timeout` is set.
- R8: `station_addr[7:0]` is word 0 bits 7:0, `[15:8]` is word 0 bits 15:8, `[23:16]` is word 1 bits 7:0, and so on up to `[47:40]`, which is word 2 bits 15:8.
- R9: While `done` is 1, `rd_data` returns the stored word at `rd_addr`. While `done` is 0, `rd_data` and `station_addr` read 0.
- R10: A load starts by itself after reset. A `start` pulse while idle clears `done` and the flags and runs a fresh load. A `start` pulse during a load is ignored, so that load still issues exactly 64 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Re-run the load when idle |
| size_256 | input | 1 | Strap: 1 selects the 8-bit address field |
| arb_req | output | 1 | Request for the shared EEPROM pins |
| arb_gnt | input | 1 | Grant from the pin arbiter |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| done | output | 1 | Load finished (normally or by timeout) |
| grant_timeout | output | 1 | Grant never arrived |
| csum_ok | output | 1 | Image sum matched the signature |
| csum_err | output | 1 | Image sum did not match |
| rd_addr | input | 6 | Word index for the read port |
| rd_data | output | 16 | Stored word at `rd_addr` |
| station_addr | output | 48 | Station address from words 0 to 2 |

## Verification
The assertions rely on reset being applied before the first load and on DIV being at least 2, so that every serial phase spans at least two clocks. They also assume the arbiter keeps its grant for the whole load once it has been given. The bench's arbiter grants only while a request is pending, after a random delay shorter than the poll limit, and never withdraws a grant in the middle of a load. The only exception is one run in which it withholds the grant entirely. The EEPROM model changes `ee_do` only on rising edges of `ee_sk`, so the data line is settled well before the loader samples it in the clock-high phase.

// File: rtl/mw_eeprom_loader.sv
module mw_eeprom_loader #(
  parameter int          DIV       = 4,
  parameter int          GNT_POLLS = 1000,
  parameter logic [15:0] SIG       = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        size_256,
  output logic        arb_req,
  input  logic        arb_gnt,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        done,
  output logic        grant_timeout,
  output logic        csum_ok,
  output logic        csum_err,
  input  logic [5:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic [47:0] station_addr
);
  localparam int NWORDS = 64;
  localparam int AW     = $clog2(NWORDS);
  localparam int DW     = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int PW     = $clog2(GNT_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CSON, S_CMD, S_DATA, S_CSOFF} st_t;

  st_t            st;
  logic           pend, size8;
  logic [DW-1:0]  div_cnt;
  logic [PW-1:0]  polls;
  logic [AW-1:0]  waddr;
  logic [3:0]     bidx;
  logic [1:0]     ph;
  logic [15:0]    shw, sum;
  logic [15:0]    mem [NWORDS];
  logic [10:0]    cmd;

  wire tick = (div_cnt == DW'(DIV - 1));
  wire [15:0] sum_next = sum + shw;

  assign cmd = size8 ? {3'b110, 2'b00, waddr} : {2'b00, 3'b110, waddr};
  assign rd_data      = done ? mem[rd_addr] : '0;
  assign station_addr = done ? {mem[2], mem[1], mem[0]} : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  always_ff @(posedge clk)
    if (tick && st == S_CSOFF) mem[waddr] <= shw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b1; size8 <= 1'b0;
      polls <= '0; waddr <= '0; bidx <= '0; ph <= '0;
      shw <= '0; sum <= '0;
      arb_req <= 1'b0; ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
      done <= 1'b0; grant_timeout <= 1'b0; csum_ok <= 1'b0; csum_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start || pend) begin
          pend <= 1'b0; size8 <= size_256;
          done <= 1'b0; grant_timeout <= 1'b0; csum_ok <= 1'b0; csum_err <= 1'b0;
          polls <= '0; waddr <= '0; sum <= '0;
          arb_req <= 1'b1; st <= S_REQ;
        end
        S_REQ: if (tick) begin
          if (arb_gnt) st <= S_CSON;
          else if (polls == PW'(GNT_POLLS - 1)) begin
            arb_req <= 1'b0; done <= 1'b1; grant_timeout <= 1'b1; st <= S_IDLE;
          end else polls <= polls + 1'b1;
        end
        S_CSON: if (tick) begin
          ee_cs <= 1'b1; ph <= 2'd0;
          bidx <= size8 ? 4'd10 : 4'd8;
          st <= S_CMD;
        end
        S_CMD: if (tick) begin
          case (ph)
            2'd0: begin ee_di <= cmd[bidx]; ph <= 2'd1; end
            2'd1: begin ee_sk <= 1'b1; ph <= 2'd2; end
            default: begin
              ee_sk <= 1'b0; ph <= 2'd0;
              if (bidx == 4'd0) begin bidx <= 4'd15; st <= S_DATA; end
              else bidx <= bidx - 1'b1;
            end
          endcase
        end
        S_DATA: if (tick) begin
          case (ph)
            2'd0: begin ee_di <= 1'b0; ph <= 2'd1; end
            2'd1: begin ee_sk <= 1'b1; ph <= 2'd2; end
            default: begin
              shw <= {shw[14:0], ee_do};
              ee_sk <= 1'b0; ph <= 2'd0;
              if (bidx == 4'd0) st <= S_CSOFF;
              else bidx <= bidx - 1'b1;
            end
          endcase
        end
        S_CSOFF: if (tick) begin
          ee_cs <= 1'b0; ee_di <= 1'b0; ee_sk <= 1'b0;
          sum <= sum_next;
          if (waddr == AW'(NWORDS - 1)) begin
            arb_req <= 1'b0; done <= 1'b1;
            csum_ok  <= (sum_next == SIG);
            csum_err <= (sum_next != SIG);
            st <= S_IDLE;
          end else begin
            waddr <= waddr + 1'b1; st <= S_CSON;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cs_owns_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> arb_req);
  p_req_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !arb_req);
  p_timeout_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_timeout |-> (done && !ee_cs && !csum_ok && !csum_err));
  p_di_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));
  p_sk_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  p_cs_drop_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_sk && !ee_di));
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csum_ok, csum_err, grant_timeout}));
endmodule

// File: tb/mw_eeprom_loader_bench.sv
module mw_eeprom_loader_bench;
  localparam int DIV = 2;
  localparam int GNT_POLLS = 1000;
  localparam logic [15:0] SIG = 16'hBABA;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, size_256 = 1'b0;
  logic arb_req, arb_gnt, ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b0;
  logic done, grant_timeout, csum_ok, csum_err;
  logic [5:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [47:0] station_addr;

  int checks = 0, errors = 0;
  logic [15:0] img [64];
  int gnt_en = 1, gnt_delay = 3, req_cnt = 0;
  int proto_err = 0, cs_rises = 0, exp_addr = 0, nbm = 9, cnt = 0, cur = 0;
  int sk_hi_run = 0, sk_hi_min = 1000000, sk_hi_max = 0;
  logic [10:0] shin = '0;
  logic prev_cs = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom_loader #(.DIV(DIV), .GNT_POLLS(GNT_POLLS), .SIG(SIG)) u_mw_eeprom_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .size_256(size_256),
    .arb_req(arb_req), .arb_gnt(arb_gnt),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .done(done), .grant_timeout(grant_timeout), .csum_ok(csum_ok), .csum_err(csum_err),
    .rd_addr(rd_addr), .rd_data(rd_data), .station_addr(station_addr));

  always @(posedge clk) req_cnt <= arb_req ? req_cnt + 1 : 0;
  assign arb_gnt = (gnt_en != 0) && arb_req && (req_cnt >= gnt_delay);

  always @(posedge ee_cs) begin cnt = 0; shin = '0; cs_rises++; end

  always @(posedge ee_sk) begin
    if (!ee_cs) proto_err++;
    else begin
      cnt++;
      if (cnt <= nbm) begin
        shin = {shin[9:0], ee_di};
        if (cnt == nbm) begin
          if (shin[nbm-1 -: 3] != 3'b110) proto_err++;
          if ((nbm == 11 ? int'(shin[7:0]) : int'(shin[5:0])) != exp_addr) proto_err++;
          cur = exp_addr % 64;
          exp_addr++;
        end
      end else if (cnt <= nbm + 16) ee_do = img[cur][15-(cnt-nbm-1)];
      else proto_err++;
    end
  end

  always @(negedge clk) begin
    if (prev_cs && !ee_cs && (ee_di || ee_sk)) proto_err++;
    if (!ee_cs && arb_req === 1'b0 && ee_sk) proto_err++;
    prev_cs = ee_cs;
    if (ee_sk) sk_hi_run++;
    else if (sk_hi_run > 0) begin
      if (sk_hi_run < sk_hi_min) sk_hi_min = sk_hi_run;
      if (sk_hi_run > sk_hi_max) sk_hi_max = sk_hi_run;
      sk_hi_run = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] img_sum();
    logic [15:0] s = '0;
    for (int i = 0; i < 64; i++) s = s + img[i];
    return s;
  endfunction

  function automatic logic [47:0] exp_station();
    return {img[2][15:8], img[2][7:0], img[1][15:8], img[1][7:0], img[0][15:8], img[0][7:0]};
  endfunction

  task automatic make_img(input bit good);
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin img[i] = 16'($urandom); s = s + img[i]; end
    img[63] = SIG - s + (good ? 16'd0 : 16'(1 + $urandom_range(0, 200)));
  endtask

  task automatic arm(input bit sz);
    size_256 = sz; nbm = sz ? 11 : 9;
    proto_err = 0; cs_rises = 0; exp_addr = 0;
    sk_hi_min = 1000000; sk_hi_max = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_load(input string tag);
    bit good = (img_sum() == SIG);
    int bad = 0;
    chk({"R7 ", tag}, {62'd0, csum_ok, csum_err}, {62'd0, good, !good});
    chk({"R2 ", tag}, grant_timeout, 0);
    chk({"R1 ", tag}, arb_req, 0);
    chk({"R3 R5 ", tag}, proto_err, 0);
    chk({"R6 ", tag}, cs_rises, 64);
    chk({"R6 order ", tag}, exp_addr, 64);
    chk({"R4 ", tag}, {32'(sk_hi_min), 32'(sk_hi_max)}, {32'(DIV), 32'(DIV)});
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i); #1;
      if (rd_data !== img[i]) bad++;
    end
    chk({"R9 ", tag}, bad, 0);
    rd_addr = 6'd63; #1;
    chk({"R9 last ", tag}, rd_data, img[63]);
    chk({"R8 ", tag}, station_addr, exp_station());
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    make_img(1'b1);
    arm(1'b0);
    repeat (3) @(negedge clk);
    chk("R10 reset done", done, 0);
    chk("R9 reset rd_data", rd_data, 0);
    chk("R6 reset pins", {ee_cs, ee_sk, ee_di}, 0);
    chk("R7 reset flags", {csum_ok, csum_err, grant_timeout}, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 busy rd_data", rd_data, 0);
    chk("R9 busy station", station_addr, 0);
    chk("R1 busy req", arb_req, 1);
    wait_done();
    check_load("auto");

    make_img(1'b1); arm(1'b1); gnt_delay = 5;
    pulse_start();
    @(negedge clk);
    chk("R10 restart clears done", done, 0);
    wait_done();
    check_load("addr8");

    make_img(1'b0); arm(1'b0); gnt_delay = 0;
    pulse_start();
    wait_done();
    check_load("bad sum");

    make_img(1'b1); arm(1'b0);
    pulse_start();
    repeat (3000) @(negedge clk);
    pulse_start();
    wait_done();
    check_load("start ignored R10");

    arm(1'b0); gnt_en = 0;
    begin
      int cyc = 0;
      pulse_start();
      while (!done) begin @(negedge clk); cyc++; end
      chk("R2 timeout flag", {grant_timeout, csum_ok, csum_err}, 3'b100);
      chk("R2 no cs", cs_rises, 0);
      chk("R2 window", (cyc >= GNT_POLLS*DIV - DIV) && (cyc <= GNT_POLLS*DIV + 2*DIV + 4), 1);
      chk("R1 timeout req", arb_req, 0);
    end
    gnt_en = 1;

    for (int n = 0; n < 2; n++) begin
      make_img($urandom_range(0, 1) == 1);
      arm($urandom_range(0, 1) == 1);
      gnt_delay = $urandom_range(0, 40);
      pulse_start();
      wait_done();
      check_load("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule